// File: doc/BRIEF.md
# Pin Controller with Grouped Interrupt Summaries

This block is a bank of general-purpose I/O lines. A single-cycle register port sets each line's direction and drive level. It can make an output line blink, and it can invert how each input line is seen. Each raw input passes through a synchroniser. The bank then applies a per-line XOR polarity to form the "sampled view" of the inputs.

The sampled view feeds two interrupt paths. The level path uses the sampled view directly. The edge path latches a sticky cause bit whenever a sampled bit rises from 0 to 1. Each path has its own mask. For each line, the two masked paths are ORed. Consecutive runs of eight lines are then ORed into one summary output each, for an upstream cause collector.

To catch a falling edge, software sets the line's polarity bit. To catch both edges, software flips polarity after each event. Register reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction register (select 0) reads all ones, so every line is an input and `pin_oe` is all zero. The output (select 1), blink (select 2), polarity (select 3), edge cause (select 5), edge mask (select 6) and level mask (select 7) registers read zero, and `irq_group` is zero.
- R2: The sampled view (select 4, read-only) equals the synchronised pins XOR the polarity register. A write to select 4 has no effect.
- R3: A change on `pin_in` appears in the sampled view exactly two rising clock edges later, and not after one.
- R4: A direction bit of 1 makes the line an input and a 0 makes it an output: `pin_oe` is the inverse of the direction register. With blink off, `pin_out` equals the output register.
- R5: The line-value read (select 8) returns the sampled-view bit for input lines and the output-register bit for output lines.
- R6: For a line whose blink bit is 1, `pin_out` equals bit BLINK_LOG2 of a prescaler that counts clocks from 0 after reset, so the line toggles every 2^BLINK_LOG2 cycles. Blink does not alter the output register's stored value.
- R7: Level interrupt: a line whose level mask bit is 1 and whose sampled-view bit is 1 raises its group's summary. Clearing the mask bit removes it.
- R8: An edge cause bit (select 5) is set when its sampled-view bit goes from 0 to 1, one edge after the view changes. A 1-to-0 change sets nothing, and set bits stay set.
- R9: Writing select 5 clears every cause bit written as 0 and keeps every bit written as 1.
- R10: `irq_group[g]` is the OR over lines 8g to 8g+7 of (level mask AND sampled view) OR (edge mask AND edge cause).
- R11: With the polarity bit set, a falling pin level latches an edge cause, and a rising pin level does not.
- R12: If a clearing write to select 5 and a new rising sample land on the same edge, the new cause bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (4) | Register select |
| reg_wdata | input | NUM_PINS (32) | Write data |
| reg_rdata | output | NUM_PINS (32) | Read data for the selected register, combinational |
| pin_in | input | NUM_PINS (32) | Raw line levels from the pads |
| pin_out | output | NUM_PINS (32) | Level driven on each line |
| pin_oe | output | NUM_PINS (32) | Output enable per line, 1 drives |
| irq_group | output | NUM_PINS/GROUP_SIZE (4) | One summary interrupt per group of eight lines |

## Verification
The bench samples the sampled view one and two edges after a pin change. An extra or missing synchroniser stage therefore shows up as a mismatch in that exact cycle. It drops a cause bit with a falling input to catch a detector that fires on any change. It writes a mixed clear pattern to catch a clear that treats written ones as clears. It times a clear to land on the same edge as a new rise, which exposes a clear that wins over a new event. It also sets interrupts in separate groups, to catch a reduction that routes a line to the wrong summary output.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // Register selects on the single-cycle port
   typedef enum logic [3:0] {
      SEL_DIR    = 4'd0,
      SEL_OUT    = 4'd1,
      SEL_BLINK  = 4'd2,
      SEL_POL    = 4'd3,
      SEL_VIEW   = 4'd4,
      SEL_ECAUSE = 4'd5,
      SEL_EMASK  = 4'd6,
      SEL_LMASK  = 4'd7,
      SEL_PINVAL = 4'd8
   } reg_sel_e;

   localparam int SEL_BITS = 4;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
   parameter int WIDTH     = 32,
   parameter int BLINK_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] blink_en_i,
   output logic [WIDTH-1:0] drive_o
);

   localparam int CNT_W = BLINK_LOG2 + 1;

   if (BLINK_LOG2 < 1) begin : g_bad_rate
      $error("gpio_blink_gen: BLINK_LOG2 must be at least 1");
   end

   logic [CNT_W-1:0] presc_q;
   logic             phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc_q <= '0;
      else        presc_q <= presc_q + CNT_W'(1);
   end

   assign phase = presc_q[CNT_W-1];

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign drive_o[i] = blink_en_i[i] ? phase : level_i[i];
   end

endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
   parameter int WIDTH      = 32,
   parameter int GROUP_SIZE = 8,
   localparam int NGROUPS   = WIDTH / GROUP_SIZE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   view_i,
   input  logic               clr_we_i,
   input  logic [WIDTH-1:0]   clr_keep_i,
   input  logic [WIDTH-1:0]   lmask_i,
   input  logic [WIDTH-1:0]   emask_i,
   output logic [WIDTH-1:0]   rise_o,
   output logic [WIDTH-1:0]   cause_o,
   output logic [NGROUPS-1:0] irq_o
);

   logic [WIDTH-1:0] view_q;
   logic [WIDTH-1:0] cause_q;
   logic [WIDTH-1:0] keep;
   logic [WIDTH-1:0] active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) view_q <= '0;
      else        view_q <= view_i;
   end

   assign rise_o = view_i & ~view_q;
   assign keep   = clr_we_i ? clr_keep_i : '1;

   // a fresh rise wins over a clearing write on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_q & keep) | rise_o;
   end

   assign cause_o = cause_q;
   assign active  = (view_i & lmask_i) | (cause_q & emask_i);

   for (genvar g = 0; g < NGROUPS; g++) begin : g_group
      assign irq_o[g] = |active[g*GROUP_SIZE +: GROUP_SIZE];
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int GROUP_SIZE  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BLINK_LOG2  = 4,
   parameter int ADDR_W      = 4,
   localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [NUM_PINS-1:0]   reg_wdata,
   output logic [NUM_PINS-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_GROUPS-1:0] irq_group
);

   if (NUM_PINS % GROUP_SIZE != 0) begin : g_bad_group
      $error("gpio_irq_ctrl: NUM_PINS must be a multiple of GROUP_SIZE");
   end
   if (ADDR_W < SEL_BITS) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W too narrow for the register selects");
   end

   logic [NUM_PINS-1:0] dir_q, out_q, blink_q, pol_q, emask_q, lmask_q;
   logic [NUM_PINS-1:0] sync_w, view_w, rise_w, cause_w;
   logic                cause_we;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e s);
      return a == ADDR_W'(s);
   endfunction

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '1;
         out_q   <= '0;
         blink_q <= '0;
         pol_q   <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else if (reg_we) begin
         if (hit(reg_addr, SEL_DIR))   dir_q   <= reg_wdata;
         if (hit(reg_addr, SEL_OUT))   out_q   <= reg_wdata;
         if (hit(reg_addr, SEL_BLINK)) blink_q <= reg_wdata;
         if (hit(reg_addr, SEL_POL))   pol_q   <= reg_wdata;
         if (hit(reg_addr, SEL_EMASK)) emask_q <= reg_wdata;
         if (hit(reg_addr, SEL_LMASK)) lmask_q <= reg_wdata;
      end
   end

   assign cause_we = reg_we && hit(reg_addr, SEL_ECAUSE);

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_in),
      .sync_o (sync_w)
   );

   assign view_w = sync_w ^ pol_q;

   gpio_irq_cause #(
      .WIDTH      (NUM_PINS),
      .GROUP_SIZE (GROUP_SIZE)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .view_i     (view_w),
      .clr_we_i   (cause_we),
      .clr_keep_i (reg_wdata),
      .lmask_i    (lmask_q),
      .emask_i    (emask_q),
      .rise_o     (rise_w),
      .cause_o    (cause_w),
      .irq_o      (irq_group)
   );

   gpio_blink_gen #(
      .WIDTH      (NUM_PINS),
      .BLINK_LOG2 (BLINK_LOG2)
   ) u_blink (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (out_q),
      .blink_en_i (blink_q),
      .drive_o    (pin_out)
   );

   assign pin_oe = ~dir_q;

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, SEL_DIR))    reg_rdata = dir_q;
      if (hit(reg_addr, SEL_OUT))    reg_rdata = out_q;
      if (hit(reg_addr, SEL_BLINK))  reg_rdata = blink_q;
      if (hit(reg_addr, SEL_POL))    reg_rdata = pol_q;
      if (hit(reg_addr, SEL_VIEW))   reg_rdata = view_w;
      if (hit(reg_addr, SEL_ECAUSE)) reg_rdata = cause_w;
      if (hit(reg_addr, SEL_EMASK))  reg_rdata = emask_q;
      if (hit(reg_addr, SEL_LMASK))  reg_rdata = lmask_q;
      if (hit(reg_addr, SEL_PINVAL)) reg_rdata = (dir_q & view_w) | (~dir_q & out_q);
   end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
   parameter int NUM_PINS   = 32,
   parameter int NUM_GROUPS = 4,
   parameter int ADDR_W     = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_we,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [NUM_PINS-1:0]   pin_in,
   input logic [NUM_PINS-1:0]   pin_out,
   input logic [NUM_PINS-1:0]   dir_q,
   input logic [NUM_PINS-1:0]   out_q,
   input logic [NUM_PINS-1:0]   blink_q,
   input logic [NUM_PINS-1:0]   pol_q,
   input logic [NUM_PINS-1:0]   lmask_q,
   input logic [NUM_PINS-1:0]   emask_q,
   input logic [NUM_PINS-1:0]   view_w,
   input logic [NUM_PINS-1:0]   rise_w,
   input logic [NUM_PINS-1:0]   cause_w,
   input logic [NUM_GROUPS-1:0] irq_group
);

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age_q <= '0;
      else if (age_q != 3) age_q <= age_q + 2'd1;
   end

   // R1: first cycle out of reset sees the reset register values
   p_reset_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 0) |-> (dir_q == '1 && cause_w == '0 && irq_group == '0));

   // R3: two-edge latency from pin to sampled view while polarity is steady
   p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2 && $stable(pol_q)) |-> (view_w == ($past(pin_in, 2) ^ pol_q)));

   // R4: blink-off output lines follow the output register
   p_drive_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ out_q) & ~blink_q & ~dir_q) == '0);

   // R8: a rising sample is latched on the next edge
   p_rise_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_w != '0) |=> ((cause_w & $past(rise_w)) == $past(rise_w)));

   // R9: cause bits only drop through a write to the cause select
   p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == ADDR_W'(5)) |=> ((cause_w & $past(cause_w)) == $past(cause_w)));

   // R10: no mask bit set means no summary interrupt
   p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lmask_q == '0 && emask_q == '0) |-> (irq_group == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_PINS   (NUM_PINS),
   .NUM_GROUPS (NUM_GROUPS),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .dir_q     (dir_q),
   .out_q     (out_q),
   .blink_q   (blink_q),
   .pol_q     (pol_q),
   .lmask_q   (lmask_q),
   .emask_q   (emask_q),
   .view_w    (view_w),
   .rise_w    (rise_w),
   .cause_w   (cause_w),
   .irq_group (irq_group)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;

   localparam int NP = 32;
   localparam int NG = 4;
   localparam int BL = 3;

   // kind codes for scoreboard items
   localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IRQ = 3;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          reg_we = 0;
   logic [3:0]    reg_addr = 0;
   logic [NP-1:0] reg_wdata = 0;
   logic [NP-1:0] reg_rdata;
   logic [NP-1:0] pin_in = 0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic [NG-1:0] irq_group;

   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 0;
   int    bc = 0;
   item_t sb[$];

   always #2 clk = ~clk;   // 250 MHz

   gpio_irq_ctrl #(.BLINK_LOG2(BL)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_group(irq_group)
   );

   // clocks since reset, the prescaler the requirement describes
   always @(posedge clk) begin
      if (!rst_n) bc <= 0;
      else        bc <= bc + 1;
   end

   // monitor: compare queued expectations just after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
               K_RD:    act = reg_rdata;
               K_OUT:   act = pin_out;
               K_OE:    act = pin_oe;
               default: act = {28'd0, irq_group};
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_err++;
               $display("FAIL %s: actual=%08h expected=%08h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_we = 0;
   endtask

   task automatic chk(input int kind, input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a;
      it.kind = kind; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic set_pins(input logic [31:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_blink(input logic [31:0] outreg);
      item_t it;
      logic ph;
      @(negedge clk);
      ph = bc[BL];
      it.kind = K_OUT;
      it.exp = (outreg & ~32'h3) | (ph ? 32'h3 : 32'h0);
      it.tag = "R6 blink drive";
      sb.push_back(it);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      chk(K_RD, 0, 32'hFFFF_FFFF, "R1 dir reset");
      chk(K_RD, 1, 32'h0, "R1 out reset");
      chk(K_RD, 2, 32'h0, "R1 blink reset");
      chk(K_RD, 3, 32'h0, "R1 pol reset");
      chk(K_RD, 5, 32'h0, "R1 cause reset");
      chk(K_RD, 6, 32'h0, "R1 emask reset");
      chk(K_RD, 7, 32'h0, "R1 lmask reset");
      chk(K_OE, 0, 32'h0, "R1 oe reset");
      chk(K_IRQ, 0, 32'h0, "R1 irq reset");

      // R3 latency, R2 polarity view
      set_pins(32'hA5A5_A5A5);
      chk(K_RD, 4, 32'h0, "R3 not after one edge");
      chk(K_RD, 4, 32'hA5A5_A5A5, "R3 after two edges");
      wr(3, 32'h0F0F_0F0F);
      chk(K_RD, 4, 32'hAAAA_AAAA, "R2 polarity xor");
      wr(4, 32'h0);
      chk(K_RD, 4, 32'hAAAA_AAAA, "R2 view write ignored");
      wr(3, 32'h0);
      set_pins(32'h0);
      idle(3);
      wr(5, 32'h0);
      chk(K_RD, 5, 32'h0, "R9 clear all");

      // R4 direction and level
      wr(0, 32'hFFFF_0000);
      wr(1, 32'h5A5A_1234);
      chk(K_OE, 0, 32'h0000_FFFF, "R4 oe from dir");
      chk(K_OUT, 0, 32'h5A5A_1234, "R4 out level");

      // R5 line value
      set_pins(32'h0F0F_0000);
      idle(2);
      chk(K_RD, 8, 32'h0F0F_1234, "R5 line value mix");

      // R6 blink on lines 0 and 1
      wr(2, 32'h0000_0003);
      chk_blink(32'h5A5A_1234);
      idle(3);
      chk_blink(32'h5A5A_1234);
      idle(3);
      chk_blink(32'h5A5A_1234);
      idle(2);
      chk_blink(32'h5A5A_1234);
      chk(K_RD, 1, 32'h5A5A_1234, "R6 out reg untouched");
      wr(2, 32'h0);
      chk(K_OUT, 0, 32'h5A5A_1234, "R6 blink off");

      wr(0, 32'hFFFF_FFFF);
      set_pins(32'h0);
      idle(3);
      wr(5, 32'h0);
      chk(K_RD, 5, 32'h0, "R9 clear all again");

      // R7 level path
      wr(7, 32'h0000_0008);
      chk(K_IRQ, 0, 32'h0, "R7 idle level");
      set_pins(32'h0000_0008);
      idle(1);
      chk(K_IRQ, 0, 32'h1, "R7 level raised");
      wr(7, 32'h0);
      chk(K_IRQ, 0, 32'h0, "R7 level masked");

      // R8 edge latch
      chk(K_RD, 5, 32'h0000_0008, "R8 rise latched");
      set_pins(32'h0000_0208);
      idle(2);
      chk(K_RD, 5, 32'h0000_0208, "R8 second rise");
      set_pins(32'h0000_0200);
      idle(3);
      chk(K_RD, 5, 32'h0000_0208, "R8 fall ignored");
      set_pins(32'h0002_0200);
      idle(2);
      chk(K_RD, 5, 32'h0002_0208, "R8 third rise");

      // R9 mixed clear
      wr(5, ~32'h0000_0200);
      chk(K_RD, 5, 32'h0002_0008, "R9 partial clear");

      // R10 grouping
      wr(6, 32'h0002_0000);
      chk(K_IRQ, 0, 32'h4, "R10 edge group2");
      wr(6, 32'h0000_0008);
      chk(K_IRQ, 0, 32'h1, "R10 edge group0");
      wr(6, 32'h0);
      chk(K_IRQ, 0, 32'h0, "R10 edge masked");
      wr(7, 32'h0002_0200);
      chk(K_IRQ, 0, 32'h6, "R10 level groups 1 and 2");
      wr(7, 32'h0);

      // R11 inverted polarity catches a fall
      wr(5, 32'h0);
      set_pins(32'h0010_0000);
      idle(3);
      chk(K_RD, 5, 32'h0010_0000, "R11 plain rise");
      wr(5, 32'h0);
      wr(3, 32'h0010_0000);
      idle(2);
      chk(K_RD, 5, 32'h0, "R11 no cause on view fall");
      set_pins(32'h0);
      idle(2);
      chk(K_RD, 5, 32'h0010_0000, "R11 falling pin latched");

      // R12 rise and clear on the same edge
      set_pins(32'h0000_0001);
      idle(1);
      wr(5, 32'h0);
      chk(K_RD, 5, 32'h0000_0001, "R12 rise beats clear");

      idle(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule